// File: doc/BRIEF.md
# PCM Frame Position Counter with Sync Check

This block tracks the position of the current bit within a frame on a serial PCM highway. It advances once per bit clock and reports three things: the running bit number within the frame, the timeslot index and the bit index inside that timeslot. It also raises a one-cycle strobe on the first bit of every frame.

The frame length comes from an 8-bit programmed length code and a 2-bit scale mode. The code is scaled by 1, 2 or 4, which covers frames of up to 1024 bits. When no sync pulse arrives, the counter wraps at the programmed length on its own. An external frame-sync pulse restarts it at any point. The block compares every sync pulse with the frame boundary the counter expects. It sets a status flag when the two agree and clears the flag when they do not.

Length and mode changes do not cut into the frame in progress. They are taken up at the next frame boundary. Software must program a legal length: a multiple of 32 bits for scale 1, of 64 bits for scale 2 and of 128 bits for scale 4.

Top module: `pcm_frame_counter`

## Requirements
- R1: After reset the bit count is 0, the sync status is 0 and the frame-start strobe is 1. The first frame after reset is 256 bits long (length code 0xFF, mode 0), whatever the inputs hold.
- R2: In mode 0 (cfg_mode = 2'd0) a frame without sync pulses lasts length code + 1 bit clocks. The count rises by one each clock and returns to 0 after the last bit.
- R3: In modes 1 and 3 (cfg_mode = 2'd1 or 2'd3) a frame without sync pulses lasts 2 × (length code + 1) bit clocks.
- R4: In mode 2 (cfg_mode = 2'd2) a frame without sync pulses lasts 4 × (length code + 1) bit clocks.
- R5: A sync input that is high at a clock edge makes the count 0 after that edge, whatever the count was before.
- R6: The timeslot index equals the bit count divided by 8, and the bit-in-timeslot index equals the bit count modulo 8.
- R7: The frame-start strobe is high in exactly the cycles where the bit count is 0.
- R8: A sync pulse sampled while the count is at the last bit of the frame sets the sync status to 1 after that edge.
- R9: A sync pulse sampled at any other count clears the sync status after that edge.
- R10: When the counter wraps with no sync pulse sampled at the last bit, the sync status is cleared after that edge.
- R11: A new length code or mode is applied at the next clock edge that returns the count to 0. The frame in progress keeps its old length.
- R12: The sync status does not change at edges where neither a sync pulse nor a wrap occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_len | input | 8 | Programmed frame length code |
| cfg_mode | input | 2 | Scale mode: 0 gives ×1, 1 and 3 give ×2, 2 gives ×4 |
| fsync | input | 1 | Frame-sync pulse, sampled on the bit clock; the count is 0 after an edge where it is high |
| bit_cnt | output | 10 | Bit position within the frame |
| slot_idx | output | 7 | Timeslot index (bit_cnt / 8) |
| bit_in_slot | output | 3 | Bit within timeslot (bit_cnt mod 8) |
| frame_start | output | 1 | High while bit_cnt is 0 |
| sync_ok | output | 1 | Sync pulses agree with the programmed frame length |

## Verification
The counter is driven with short frames in each scale mode, including mode 3, which is an alias of mode 1. Measuring the spacing between frame-start strobes shows whether each scale factor is decoded correctly. Sync pulses are placed exactly on the last bit and also part-way through a frame, and frames are run with no pulse at all. This separates the set, clear and miss paths of the status flag and shows that the count restarts. A length change made in the middle of a frame shows whether the new length is applied at once or only at the boundary. A cycle-level model compares every output on every clock.

// File: rtl/pcm_frame_pkg.sv
package pcm_frame_pkg;
  // Scale modes for the length code
  typedef enum logic [1:0] {
    PCM_SCALE_X1  = 2'd0,
    PCM_SCALE_X2  = 2'd1,
    PCM_SCALE_X4  = 2'd2,
    PCM_SCALE_X2B = 2'd3
  } pcm_scale_e;

  localparam int unsigned SLOT_BITS = 3;   // 8 bits per timeslot
  localparam int unsigned SCALE_BITS = 2;  // widest scale is x4
endpackage

// File: rtl/pcm_len_decode.sv
module pcm_len_decode #(
  parameter int unsigned LEN_W = 8,
  localparam int unsigned CNT_W = LEN_W + pcm_frame_pkg::SCALE_BITS
) (
  input  logic [LEN_W-1:0] len_code,
  input  logic [1:0]       mode,
  output logic [CNT_W-1:0] last_idx
);
  import pcm_frame_pkg::*;

  // scaled length minus one: no adder is needed, the low bits fill with ones
  always_comb begin
    unique case (pcm_scale_e'(mode))
      PCM_SCALE_X1: last_idx = {2'b00, len_code};
      PCM_SCALE_X4: last_idx = {len_code, 2'b11};
      default:      last_idx = {1'b0, len_code, 1'b1};
    endcase
  end
endmodule

// File: rtl/pcm_bit_counter.sv
module pcm_bit_counter #(
  parameter int unsigned LEN_W    = 8,
  parameter logic [7:0]  RST_LEN  = 8'hFF,
  parameter logic [1:0]  RST_MODE = 2'd0,
  localparam int unsigned CNT_W = LEN_W + pcm_frame_pkg::SCALE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [1:0]       cfg_mode,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);
  logic [LEN_W-1:0] act_len, act_len_nxt;
  logic [1:0]       act_mode, act_mode_nxt;
  logic [CNT_W-1:0] cnt_nxt, last_idx;
  logic             boundary;

  pcm_len_decode #(.LEN_W(LEN_W)) u_dec (
    .len_code (act_len),
    .mode     (act_mode),
    .last_idx (last_idx)
  );

  assign at_last  = (cnt == last_idx);
  assign boundary = fsync | at_last;

  always_comb begin
    cnt_nxt      = cnt + CNT_W'(1);
    act_len_nxt  = act_len;
    act_mode_nxt = act_mode;
    if (boundary) begin
      cnt_nxt      = '0;
      act_len_nxt  = cfg_len;
      act_mode_nxt = cfg_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      act_len  <= LEN_W'(RST_LEN);
      act_mode <= RST_MODE;
    end else begin
      cnt      <= cnt_nxt;
      act_len  <= act_len_nxt;
      act_mode <= act_mode_nxt;
    end
  end

  // count never passes the active last index (R2)
  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_idx);
  // count advances by one inside a frame (R2)
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && !at_last) |=> (cnt == $past(cnt) + CNT_W'(1)));
  // wrap to zero after the last bit (R2)
  assert_count_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && at_last) |=> (cnt == '0));
  // sync forces the count to zero (R5)
  assert_sync_realign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (cnt == '0));
  // active length held inside a frame (R11)
  assert_cfg_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && !at_last) |=> $stable(last_idx));
endmodule

// File: rtl/pcm_sync_monitor.sv
module pcm_sync_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  input  logic at_last,
  output logic sync_ok
);
  logic sync_ok_nxt;

  always_comb begin
    sync_ok_nxt = sync_ok;
    if (fsync)        sync_ok_nxt = at_last;
    else if (at_last) sync_ok_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_ok <= 1'b0;
    else        sync_ok <= sync_ok_nxt;
  end

  // pulse on boundary sets the flag (R8)
  assert_sync_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && at_last) |=> sync_ok);
  // early or late pulse clears the flag (R9)
  assert_sync_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && !at_last) |=> !sync_ok);
  // wrap without a pulse clears the flag (R10)
  assert_sync_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && at_last) |=> !sync_ok);
  // flag held otherwise (R12)
  assert_sync_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && !at_last) |=> $stable(sync_ok));
endmodule

// File: rtl/pcm_frame_counter.sv
module pcm_frame_counter #(
  parameter int unsigned LEN_W    = 8,
  parameter logic [7:0]  RST_LEN  = 8'hFF,
  parameter logic [1:0]  RST_MODE = 2'd0,
  localparam int unsigned CNT_W  = LEN_W + pcm_frame_pkg::SCALE_BITS,
  localparam int unsigned SLOT_W = CNT_W - pcm_frame_pkg::SLOT_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [1:0]          cfg_mode,
  input  logic                fsync,
  output logic [CNT_W-1:0]    bit_cnt,
  output logic [SLOT_W-1:0]   slot_idx,
  output logic [pcm_frame_pkg::SLOT_BITS-1:0] bit_in_slot,
  output logic                frame_start,
  output logic                sync_ok
);
  logic at_last;

  pcm_bit_counter #(
    .LEN_W    (LEN_W),
    .RST_LEN  (RST_LEN),
    .RST_MODE (RST_MODE)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsync    (fsync),
    .cfg_len  (cfg_len),
    .cfg_mode (cfg_mode),
    .cnt      (bit_cnt),
    .at_last  (at_last)
  );

  pcm_sync_monitor u_mon (
    .clk     (clk),
    .rst_n   (rst_n),
    .fsync   (fsync),
    .at_last (at_last),
    .sync_ok (sync_ok)
  );

  assign slot_idx    = bit_cnt[CNT_W-1:pcm_frame_pkg::SLOT_BITS];
  assign bit_in_slot = bit_cnt[pcm_frame_pkg::SLOT_BITS-1:0];
  assign frame_start = (bit_cnt == '0);

  // strobe implies slot and bit fields both zero (R7)
  assert_frame_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (slot_idx == '0 && bit_in_slot == '0));
  // strobe follows a boundary edge (R7)
  assert_start_after_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync || at_last) |=> frame_start);
endmodule

// File: tb/pcm_frame_counter_tb.sv
`timescale 1ns/1ps
module pcm_frame_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cfg_len;
  logic [1:0] cfg_mode;
  logic       fsync;
  logic [9:0] bit_cnt;
  logic [6:0] slot_idx;
  logic [2:0] bit_in_slot;
  logic       frame_start;
  logic       sync_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  int exp_cnt;
  int exp_len;
  bit exp_ok;

  always #2.5 clk = ~clk;

  pcm_frame_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_mode(cfg_mode),
    .fsync(fsync), .bit_cnt(bit_cnt), .slot_idx(slot_idx),
    .bit_in_slot(bit_in_slot), .frame_start(frame_start), .sync_ok(sync_ok)
  );

  function automatic int len_of(input logic [7:0] v, input logic [1:0] m);
    if (m == 2'd0)      return int'(v) + 1;
    else if (m == 2'd2) return 4 * (int'(v) + 1);
    else                return 2 * (int'(v) + 1);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "bit_cnt", int'(bit_cnt), exp_cnt);
    check("R6", "slot_idx", int'(slot_idx), exp_cnt / 8);
    check("R6", "bit_in_slot", int'(bit_in_slot), exp_cnt % 8);
    check("R7", "frame_start", int'(frame_start), (exp_cnt == 0) ? 1 : 0);
    check(tag, "sync_ok", int'(sync_ok), int'(exp_ok));
  endtask

  // one bit clock with model update; inputs change 1 ns after the edge
  task automatic tick(input bit fs, input string tag);
    bit last;
    fsync = fs;
    last = (exp_cnt == exp_len - 1);
    if (fs) begin
      exp_ok = last;
      exp_cnt = 0;
    end else if (last) begin
      exp_ok = 1'b0;
      exp_cnt = 0;
    end else begin
      exp_cnt++;
    end
    if (exp_cnt == 0) exp_len = len_of(cfg_len, cfg_mode);
    @(posedge clk);
    #1;
    fsync = 1'b0;
    compare_all(tag);
  endtask

  // run until the count returns to zero; return cycles taken
  task automatic to_boundary(input string tag, output int n);
    n = 0;
    do begin
      tick(1'b0, tag);
      n++;
    end while (!frame_start && n < 2000);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    fsync = 1'b0;
    cfg_len = 8'h1F;
    cfg_mode = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    exp_cnt = 0; exp_len = 256; exp_ok = 1'b0;
    compare_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    exp_cnt = 1;
    compare_all("R1");
    begin
      int n;
      to_boundary("R1", n);
      check("R1", "first frame length", n + 1, 256);
    end
  endtask

  task automatic t_mode(input logic [7:0] v, input logic [1:0] m, input string tag);
    int n;
    cfg_len = v;
    cfg_mode = m;
    to_boundary(tag, n);          // new setting taken up here
    to_boundary(tag, n);
    check(tag, "frame length", n, len_of(v, m));
  endtask

  task automatic t_slot_fields();
    int n;
    cfg_len = 8'h1F; cfg_mode = 2'd1;   // 64-bit frames
    to_boundary("R6", n);
    repeat (13) tick(1'b0, "R6");
    check("R6", "slot at bit 13", int'(slot_idx), 1);
    check("R6", "bit at bit 13", int'(bit_in_slot), 5);
    to_boundary("R6", n);
  endtask

  task automatic t_sync_boundary();
    int n;
    cfg_len = 8'h1F; cfg_mode = 2'd0;   // 32-bit frames
    to_boundary("R8", n);
    to_boundary("R8", n);
    repeat (31) tick(1'b0, "R8");
    tick(1'b1, "R8");
    check("R8", "sync_ok after aligned pulse", int'(sync_ok), 1);
    check("R8", "count after aligned pulse", int'(bit_cnt), 0);
    repeat (10) tick(1'b0, "R12");
    check("R12", "sync_ok held mid frame", int'(sync_ok), 1);
  endtask

  task automatic t_sync_early();
    repeat (5) tick(1'b0, "R9");
    check("R9", "sync_ok before early pulse", int'(sync_ok), 1);
    tick(1'b1, "R9");
    check("R5", "count after early pulse", int'(bit_cnt), 0);
    check("R9", "sync_ok after early pulse", int'(sync_ok), 0);
  endtask

  task automatic t_sync_missing();
    int n;
    repeat (31) tick(1'b0, "R10");
    tick(1'b1, "R10");
    check("R10", "sync_ok re-armed", int'(sync_ok), 1);
    to_boundary("R10", n);
    check("R10", "free-run length", n, 32);
    check("R10", "sync_ok after missed pulse", int'(sync_ok), 0);
  endtask

  task automatic t_cfg_change();
    int n;
    repeat (4) tick(1'b0, "R11");
    cfg_len = 8'h0F; cfg_mode = 2'd2;   // 64-bit frames from next boundary
    to_boundary("R11", n);
    check("R11", "old frame finishes", n, 28);
    to_boundary("R11", n);
    check("R11", "new length applied", n, 64);
  endtask

  initial begin
    t_reset();
    t_mode(8'h1F, 2'd0, "R2");
    t_mode(8'h07, 2'd0, "R2");
    t_mode(8'h1F, 2'd1, "R3");
    t_mode(8'h0F, 2'd3, "R3");
    t_mode(8'h0F, 2'd2, "R4");
    t_slot_fields();
    t_sync_boundary();
    t_sync_early();
    t_sync_missing();
    t_cfg_change();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule